// File: doc/BRIEF.md
# Multi-Channel Fractional Clock-Enable Divider

This block produces one clock-enable pulse train for each of several execution channels that share a single system clock. Each channel has a divisor made of a 16-bit integer part and an 8-bit fraction in units of 1/256. The channel's pulses arrive at an average rate equal to the system frequency divided by that divisor. When the fraction is non-zero, the pulses are spread so that most gaps are the integer part long and some are one cycle longer.

Every channel's divider runs all the time. Its pattern depends only on its divisor and on the last time it was restarted. The enable mask only gates what reaches the output. A restart vector can return any set of dividers to phase 0 on the same edge, so channels with equal divisors then pulse in exact lockstep. A start strobe enables a set of channels and restarts the same set on one edge.

Each divider is a two-state machine. `PH_COUNT` counts through the integer period. It takes the transition "wrap to count" when a period ends and the fraction accumulator does not overflow, and "wrap to stretch" when it does overflow. `PH_STRETCH` inserts exactly one idle cycle and always takes the transition "resume" back to `PH_COUNT`. A restart forces `PH_COUNT` from either state.

Top module: `clken_divider_bank`

## Requirements
- R1: While `rst_n` is low, every `clk_en` bit is low. After reset the enable mask is all clear, and every divisor is 1.0 with its divider at phase 0.
- R2: A channel whose divisor is 1.0 (integer 1, fraction 0) and whose enable bit is set pulses on every cycle.
- R3: With integer part n and fraction 0, an enabled channel pulses once every n cycles. The first pulse is on cycle n-1, where cycle 0 is the first cycle after the restart edge.
- R4: With integer part I and fraction F (the fraction is in units of 1/256), the m-th pulse (m counted from 0) after a restart falls on cycle (m+1)*I - 1 + floor(m*F/256).
- R5: An integer part of 0 acts as 65536, so the first pulse after a restart falls on cycle 65535.
- R6: Bit i of `restart_mask` puts channel i at cycle 0 on the following cycle. All bits set in the same cycle act on the same edge, so channels with equal divisors then pulse identically. Channels whose bit is clear keep their pattern.
- R7: `en_wr` loads `en_val` into the enable mask, where bit i controls channel i. A disabled channel's output is low, but its divider keeps running, so after re-enabling its pulses still fall where R4 places them counting from its last restart.
- R8: `start_wr` ORs `start_mask` into the enable mask and restarts the same channels on the same edge. If `en_wr` is also high, the start bits are ORed into the written value.
- R9: Bit i of `div_wr` loads `div_int` and `div_frac` as channel i's setting on that edge. A running divider adopts the new setting only when its current period ends (on the pulse cycle) or on a restart, so the period in progress completes with the old divisor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_wr | input | 4 | Per-channel divisor write strobes |
| div_int | input | 16 | Integer part of the divisor being written (0 means 65536) |
| div_frac | input | 8 | Fractional part of the divisor being written, in units of 1/256 |
| en_wr | input | 1 | Load the enable mask from `en_val` |
| en_val | input | 4 | New enable mask, bit i for channel i |
| restart_mask | input | 4 | Per-channel restart to phase 0 |
| start_wr | input | 1 | Combined enable-and-restart strobe |
| start_mask | input | 4 | Channels acted on by `start_wr` |
| clk_en | output | 4 | Per-channel clock-enable pulses |

## Verification
The bench targets the places where a divider tends to slip by a cycle:
- Fractional divisors whose accumulator overflows on back-to-back periods. A design that dropped or doubled the stretch cycle would drift away from the closed-form pulse positions.
- A divisor rewritten in mid-period. A design that reloaded at once would truncate the period and pulse too early.
- A channel disabled and then re-enabled. A design that froze or reset its divider while disabled would come back out of phase with a peer that was never disabled.
- Channels first restarted apart and then restarted together, which must pulse identically from that edge on.
- The combined start, and the 65536-cycle case for an integer part of 0.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
    parameter int DEF_CH     = 4;
    parameter int DEF_INT_W  = 16;
    parameter int DEF_FRAC_W = 8;

    typedef enum logic [0:0] {
        PH_COUNT   = 1'b0,
        PH_STRETCH = 1'b1
    } div_phase_e;
endpackage

// File: rtl/clkdiv_cfg_bank.sv
module clkdiv_cfg_bank
    import clkdiv_pkg::*;
#(
    parameter int NCH    = DEF_CH,
    parameter int INT_W  = DEF_INT_W,
    parameter int FRAC_W = DEF_FRAC_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NCH-1:0]               div_wr,
    input  logic [INT_W-1:0]             div_int,
    input  logic [FRAC_W-1:0]            div_frac,
    output logic [NCH-1:0][INT_W-1:0]    cfg_int,
    output logic [NCH-1:0][FRAC_W-1:0]   cfg_frac
);
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cfg_int[c]  <= INT_W'(1);
                cfg_frac[c] <= '0;
            end else if (div_wr[c]) begin
                cfg_int[c]  <= div_int;
                cfg_frac[c] <= div_frac;
            end
        end
    end
endmodule

// File: rtl/clkdiv_mask_ctl.sv
module clkdiv_mask_ctl
    import clkdiv_pkg::*;
#(
    parameter int NCH = DEF_CH
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           en_wr,
    input  logic [NCH-1:0] en_val,
    input  logic [NCH-1:0] restart_mask,
    input  logic           start_wr,
    input  logic [NCH-1:0] start_mask,
    output logic [NCH-1:0] en_q,
    output logic [NCH-1:0] restart_vec
);
    logic [NCH-1:0] start_bits;

    assign start_bits  = start_wr ? start_mask : '0;
    assign restart_vec = restart_mask | start_bits;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (en_wr || start_wr) begin
            en_q <= (en_wr ? en_val : en_q) | start_bits;
        end
    end

    // R8: every channel named by a start is enabled on the next cycle
    a_r8_start_enables: assert property (@(posedge clk) disable iff (!rst_n)
        start_wr |=> ((en_q & $past(start_mask)) == $past(start_mask)));

    // R7: the mask changes only through a write or a start
    a_r7_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_wr && !start_wr) |=> $stable(en_q));
endmodule

// File: rtl/clkdiv_phase_gen.sv
module clkdiv_phase_gen
    import clkdiv_pkg::*;
#(
    parameter int INT_W  = DEF_INT_W,
    parameter int FRAC_W = DEF_FRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic [INT_W-1:0]  cfg_int,
    input  logic [FRAC_W-1:0] cfg_frac,
    output logic              tick
);
    div_phase_e        phase_q, phase_d;
    logic [INT_W-1:0]  cnt_q, cnt_d;
    logic [INT_W-1:0]  act_int_q, act_int_d;
    logic [FRAC_W-1:0] act_frac_q, act_frac_d;
    logic [FRAC_W-1:0] acc_q, acc_d;
    logic [FRAC_W:0]   acc_sum;
    logic [INT_W-1:0]  last_cnt;
    logic              wrap;

    assign last_cnt = act_int_q - INT_W'(1);
    assign wrap     = (cnt_q == last_cnt);
    assign acc_sum  = {1'b0, acc_q} + {1'b0, act_frac_q};

    // next-state logic
    always_comb begin
        phase_d    = phase_q;
        cnt_d      = cnt_q;
        acc_d      = acc_q;
        act_int_d  = act_int_q;
        act_frac_d = act_frac_q;
        if (restart) begin
            phase_d    = PH_COUNT;
            cnt_d      = '0;
            acc_d      = '0;
            act_int_d  = cfg_int;
            act_frac_d = cfg_frac;
        end else begin
            unique case (phase_q)
                PH_COUNT: begin
                    if (wrap) begin
                        cnt_d      = '0;
                        acc_d      = acc_sum[FRAC_W-1:0];
                        act_int_d  = cfg_int;
                        act_frac_d = cfg_frac;
                        phase_d    = acc_sum[FRAC_W] ? PH_STRETCH : PH_COUNT;
                    end else begin
                        cnt_d = cnt_q + INT_W'(1);
                    end
                end
                PH_STRETCH: begin
                    phase_d = PH_COUNT;
                end
                default: phase_d = PH_COUNT;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q    <= PH_COUNT;
            cnt_q      <= '0;
            acc_q      <= '0;
            act_int_q  <= INT_W'(1);
            act_frac_q <= '0;
        end else begin
            phase_q    <= phase_d;
            cnt_q      <= cnt_d;
            acc_q      <= acc_d;
            act_int_q  <= act_int_d;
            act_frac_q <= act_frac_d;
        end
    end

    // outputs
    always_comb begin
        tick = (phase_q == PH_COUNT) && wrap;
    end

    // R6: a restart lands the divider at phase 0
    a_r6_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (phase_q == PH_COUNT && cnt_q == '0 && acc_q == '0));

    // R3: the period counter never passes the active integer period
    a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_COUNT && act_int_q != '0) |-> (cnt_q < act_int_q));

    // R4: an overflow inserts exactly one idle cycle
    a_r4_single_stretch: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_STRETCH) |=> (phase_q == PH_COUNT));

    // R9: the active divisor is held until a period ends or a restart
    a_r9_divisor_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !restart) |=> ($stable(act_int_q) && $stable(act_frac_q)));

    // R2: a divisor of 1.0 pulses on every counting cycle
    a_r2_full_rate: assert property (@(posedge clk) disable iff (!rst_n)
        (act_int_q == INT_W'(1) && act_frac_q == '0 && phase_q == PH_COUNT) |-> tick);
endmodule

// File: rtl/clken_divider_bank.sv
module clken_divider_bank
    import clkdiv_pkg::*;
#(
    parameter int NCH    = DEF_CH,
    parameter int INT_W  = DEF_INT_W,
    parameter int FRAC_W = DEF_FRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    div_wr,
    input  logic [INT_W-1:0]  div_int,
    input  logic [FRAC_W-1:0] div_frac,
    input  logic              en_wr,
    input  logic [NCH-1:0]    en_val,
    input  logic [NCH-1:0]    restart_mask,
    input  logic              start_wr,
    input  logic [NCH-1:0]    start_mask,
    output logic [NCH-1:0]    clk_en
);
    logic [NCH-1:0][INT_W-1:0]  cfg_int;
    logic [NCH-1:0][FRAC_W-1:0] cfg_frac;
    logic [NCH-1:0]             en_q;
    logic [NCH-1:0]             restart_vec;
    logic [NCH-1:0]             tick;

    clkdiv_cfg_bank #(.NCH(NCH), .INT_W(INT_W), .FRAC_W(FRAC_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .div_wr   (div_wr),
        .div_int  (div_int),
        .div_frac (div_frac),
        .cfg_int  (cfg_int),
        .cfg_frac (cfg_frac)
    );

    clkdiv_mask_ctl #(.NCH(NCH)) u_mask (
        .clk          (clk),
        .rst_n        (rst_n),
        .en_wr        (en_wr),
        .en_val       (en_val),
        .restart_mask (restart_mask),
        .start_wr     (start_wr),
        .start_mask   (start_mask),
        .en_q         (en_q),
        .restart_vec  (restart_vec)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_div
        clkdiv_phase_gen #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_gen (
            .clk      (clk),
            .rst_n    (rst_n),
            .restart  (restart_vec[c]),
            .cfg_int  (cfg_int[c]),
            .cfg_frac (cfg_frac[c]),
            .tick     (tick[c])
        );
    end

    assign clk_en = tick & en_q;
endmodule

// File: tb/tb_clken_divider_bank.sv
module tb_clken_divider_bank;
    import clkdiv_pkg::*;

    localparam int NCH    = DEF_CH;
    localparam int INT_W  = DEF_INT_W;
    localparam int FRAC_W = DEF_FRAC_W;
    localparam longint FSCALE = longint'(1) << FRAC_W;
    localparam longint IFULL  = longint'(1) << INT_W;
    localparam int NV = 6;
    localparam int VI [NV] = '{1, 4, 7, 2, 1, 3};
    localparam int VF [NV] = '{0, 0, 0, 64, 128, 255};

    logic              clk = 1'b0;
    logic              rst_n;
    logic [NCH-1:0]    div_wr;
    logic [INT_W-1:0]  div_int;
    logic [FRAC_W-1:0] div_frac;
    logic              en_wr;
    logic [NCH-1:0]    en_val;
    logic [NCH-1:0]    restart_mask;
    logic              start_wr;
    logic [NCH-1:0]    start_mask;
    logic [NCH-1:0]    clk_en;

    always #5 clk = ~clk;

    clken_divider_bank dut (
        .clk(clk), .rst_n(rst_n), .div_wr(div_wr), .div_int(div_int),
        .div_frac(div_frac), .en_wr(en_wr), .en_val(en_val),
        .restart_mask(restart_mask), .start_wr(start_wr),
        .start_mask(start_mask), .clk_en(clk_en)
    );

    int     n_chk = 0;
    int     n_bad = 0;
    longint cyc = 0;
    longint m_rst  [NCH];
    int     m_int  [NCH];
    int     m_frac [NCH];
    bit     m_en   [NCH];
    bit     m_ok   [NCH];
    string  tag;

    always @(posedge clk) cyc <= cyc + 1;

    // pulse m lands on cycle I-1+floor(m*(I*256+F)/256) after a restart
    function automatic bit exp_tick(longint c, int iv, int fv);
        longint ie = (iv == 0) ? IFULL : longint'(iv);
        longint d  = ie * FSCALE + fv;
        longint q  = c - ie + 1;
        longint m;
        if (q < 0) return 1'b0;
        m = (q * FSCALE + d - 1) / d;
        return ((m * d) / FSCALE) == q;
    endfunction

    task automatic chk(string req, int ch, logic act, logic ex);
        n_chk++;
        if (act !== ex) begin
            n_bad++;
            $display("FAIL %s ch%0d cycle %0d: actual=%b expected=%b", req, ch, cyc, act, ex);
        end
    endtask

    task automatic compare_all();
        for (int ch = 0; ch < NCH; ch++) begin
            if (!m_en[ch]) chk(tag, ch, clk_en[ch], 1'b0);
            else if (m_ok[ch]) chk(tag, ch, clk_en[ch], exp_tick(cyc - m_rst[ch], m_int[ch], m_frac[ch]));
        end
    endtask

    task automatic run(int n);
        repeat (n) begin
            @(negedge clk);
            compare_all();
            div_wr = '0; en_wr = 1'b0; start_wr = 1'b0; restart_mask = '0;
        end
    endtask

    task automatic write_div(logic [NCH-1:0] sel, int iv, int fv);
        div_wr = sel; div_int = INT_W'(iv); div_frac = FRAC_W'(fv);
        for (int ch = 0; ch < NCH; ch++)
            if (sel[ch]) begin m_int[ch] = iv; m_frac[ch] = fv; m_ok[ch] = 1'b0; end
    endtask

    task automatic do_restart(logic [NCH-1:0] sel);
        restart_mask = sel;
        for (int ch = 0; ch < NCH; ch++)
            if (sel[ch]) begin m_rst[ch] = cyc + 1; m_ok[ch] = 1'b1; end
    endtask

    task automatic set_en(logic [NCH-1:0] val);
        en_wr = 1'b1; en_val = val;
        for (int ch = 0; ch < NCH; ch++) m_en[ch] = val[ch];
    endtask

    task automatic do_start(logic [NCH-1:0] sel);
        start_wr = 1'b1; start_mask = sel;
        for (int ch = 0; ch < NCH; ch++)
            if (sel[ch]) begin m_rst[ch] = cyc + 1; m_ok[ch] = 1'b1; m_en[ch] = 1'b1; end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog (all requirements): actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0; div_wr = '0; div_int = '0; div_frac = '0; en_wr = 1'b0;
        en_val = '0; restart_mask = '0; start_wr = 1'b0; start_mask = '0;
        for (int ch = 0; ch < NCH; ch++) begin
            m_int[ch] = 1; m_frac[ch] = 0; m_en[ch] = 1'b0; m_ok[ch] = 1'b1; m_rst[ch] = 0;
        end
        // R1: outputs low in reset, mask clear and divisor 1.0 afterwards
        tag = "R1";
        run(3);
        rst_n = 1'b1;
        run(2);
        set_en(4'b0001);
        run(6);
        set_en(4'b0000);
        run(1);

        // table of divisors, each launched by a combined start (R8)
        for (int v = 0; v < NV; v++) begin
            if (VF[v] != 0) tag = "R4+R8";
            else if (VI[v] == 1) tag = "R2+R8";
            else tag = "R3+R8";
            write_div('1, VI[v], VF[v]);
            set_en('0);
            run(1);
            do_start('1);
            run(48);
        end

        // R8: start bits are ORed over a same-cycle mask write
        tag = "R8";
        set_en(4'b0000);
        do_start(4'b0011);
        run(20);
        set_en('1);
        do_restart('1);
        run(10);

        // R9: mid-period rewrite does not cut the running period
        tag = "R9";
        write_div(4'b0001, 10, 0);
        run(1);
        do_restart(4'b0001);
        run(3);
        write_div(4'b0001, 3, 0);
        m_ok[0] = 1'b0;
        for (int c = 3; c <= 20; c++) begin
            run(1);
            chk("R9", 0, clk_en[0], (c == 9 || c == 12 || c == 15 || c == 18));
        end
        do_restart(4'b0001);
        run(10);

        // R6: separate restarts, then one masked restart brings lockstep
        tag = "R6";
        write_div(4'b1100, 2, 64);
        run(1);
        do_restart(4'b0100);
        run(5);
        do_restart(4'b1000);
        run(7);
        do_restart(4'b1100);
        for (int c = 0; c < 30; c++) begin
            run(1);
            chk("R6", 3, clk_en[3], clk_en[2]);
        end

        // R7: disabling channel 1 leaves its divider in phase
        tag = "R7";
        set_en(4'b1101);
        run(13);
        set_en(4'b1111);
        run(30);

        // R5: integer part 0 means 65536
        tag = "R5";
        write_div(4'b0010, 0, 0);
        run(1);
        do_restart(4'b0010);
        run(65540);

        summary();
        $finish;
    end
endmodule